// File: doc/BRIEF.md
# One-Time-Programmable Byte Store with Per-Block Lock Bytes

This block holds a small one-time-programmable region on a simple request/acknowledge byte bus. There are sixteen data blocks of 32 bytes each. After them sits a lock area of sixteen bytes, and byte i of that area guards data block i. Every cell starts in the erased state 0xFF. A program operation can only turn bits from 1 to 0, and nothing can ever be erased.

Every request gets a response one cycle later. That response carries an acknowledge, an error flag and a three-bit result code. Reads are accepted for any in-range address, whatever the lock state. A program request is refused in four cases: the address is out of range, the request is an erase, the data block is protected by its lock byte, or the new value would need a 0 bit to become 1. A lock byte that holds neither 0x00 nor 0xFF is treated as locking its block, and the response also raises an invalid-lock flag.

Top module: `otp_lock_mem`

## Requirements
- R1: After reset every cell reads 0xFF, and `ack_o`, `err_o`, `lock_bad_o`, `rdata_o` and `resp_o` are all zero.
- R2: A request sampled with `req_i` high on a rising edge gives `ack_o` high after that same edge, for exactly one cycle. A cycle without a request gives `ack_o` low.
- R3: A read (`we_i`=0, `erase_i`=0) to any address below 528 returns the stored byte on `rdata_o` with `resp_o`=0. Data bytes are at 0..511, and the lock byte of block i is at 512+i.
- R4: An accepted program to address a stores the written byte and returns `resp_o`=0. A program is accepted when its data has no 1 bit where the stored byte has a 0 bit. Writing the same value again is also accepted.
- R5: A program whose data has a 1 in a bit where the stored byte holds 0 is refused with `resp_o`=4, and storage does not change.
- R6: A program to data block b = addr[8:5] is refused with `resp_o`=3 while lock byte b holds 0x00, and the block does not change.
- R7: A program to a data block whose lock byte holds any value other than 0x00 or 0xFF is refused with `resp_o`=3 and `lock_bad_o`=1, and the block does not change.
- R8: A request with `erase_i`=1 is refused with `resp_o`=2 and changes no cell.
- R9: Any request to an address of 528 or above is refused with `resp_o`=1. This check has priority over every other refusal reason.
- R10: Lock bytes follow only the bit-clear rule, never a lock. Writing 0x00 again to a lock byte that already holds 0x00 is accepted.
- R11: `err_o` equals (`resp_o` != 0) whenever `ack_o` is high, and `err_o` is never high without `ack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, sets all cells to 0xFF |
| req_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = program, 0 = read |
| erase_i | input | 1 | Erase request (always refused), overrides we_i |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 8 | Program data |
| rdata_o | output | 8 | Read data, valid with ack on an accepted read |
| ack_o | output | 1 | Response strobe, one cycle after the request |
| err_o | output | 1 | Request refused |
| resp_o | output | 3 | Result: 0 ok, 1 address, 2 erase, 3 locked, 4 bit set |
| lock_bad_o | output | 1 | Target block's lock byte is neither 0x00 nor 0xFF |

## Verification
The bench drives several corner cases and checks the response and the stored data after each one.

- Partial bit clears, followed by a write that tries to restore a cleared bit. A design that simply overwrites would read back the restored value.
- A lock byte set to 0x00 and another lock byte set to a pattern that is neither value. A design that tests only for 0x00 would accept writes under the invalid pattern and never raise the flag.
- Erase attempts and out-of-range addresses, including an erase to an out-of-range address, to confirm the priority order. A wrong order would report an erase refusal there.
- Rewriting 0x00 to a lock byte that already holds 0x00. A design that treated the lock area as protected by itself would refuse this.
- A reset partway through the run, after which all programmed cells must read 0xFF again.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned NUM_BLK   = 16;
  localparam int unsigned BLK_BYTES = 32;
  localparam int unsigned DW        = 8;
  localparam int unsigned AW        = 10;
  localparam int unsigned DATA_BYTES  = NUM_BLK * BLK_BYTES;
  localparam int unsigned TOTAL_BYTES = DATA_BYTES + NUM_BLK;
  localparam int unsigned BLK_W  = $clog2(NUM_BLK);
  localparam int unsigned OFF_W  = $clog2(BLK_BYTES);
  localparam int unsigned IDX_W  = $clog2(TOTAL_BYTES);

  typedef enum logic [2:0] {
    RESP_OK     = 3'd0,
    RESP_ADDR   = 3'd1,
    RESP_ERASE  = 3'd2,
    RESP_LOCKED = 3'd3,
    RESP_SETBIT = 3'd4
  } resp_e;
endpackage

// File: rtl/otp_addr_dec.sv
module otp_addr_dec
  import otp_pkg::*;
(
  input  logic [AW-1:0]    addr_i,
  output logic             in_range_o,
  output logic             is_lock_o,
  output logic [IDX_W-1:0] tgt_idx_o,
  output logic [IDX_W-1:0] lock_idx_o
);
  logic [BLK_W-1:0] blk;

  always_comb begin
    in_range_o = (32'(addr_i) < TOTAL_BYTES);
    is_lock_o  = in_range_o && (32'(addr_i) >= DATA_BYTES);
    tgt_idx_o  = in_range_o ? addr_i[IDX_W-1:0] : '0;
    // block index of a data byte; lock bytes are not themselves guarded
    blk        = addr_i[OFF_W +: BLK_W];
    lock_idx_o = IDX_W'(DATA_BYTES) + IDX_W'(blk);
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] tgt_idx_i,
  input  logic [IDX_W-1:0] lock_idx_i,
  output logic [DW-1:0]    tgt_q_o,
  output logic [DW-1:0]    lock_q_o,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i
);
  logic [DW-1:0] cells_q [TOTAL_BYTES];

  assign tgt_q_o  = cells_q[tgt_idx_i];
  assign lock_q_o = cells_q[lock_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(TOTAL_BYTES); i++) cells_q[i] <= '1;
    end else if (wr_en_i) begin
      cells_q[tgt_idx_i] <= tgt_q_o & wr_data_i;
    end
  end

  // a committed write never needs a 0->1 transition
  assert_bit_clear_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ((wr_data_i & ~tgt_q_o) == '0));
  // written cell holds exactly the programmed value afterwards
  assert_write_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cells_q[$past(tgt_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
(
  input  logic          req_i,
  input  logic          we_i,
  input  logic          erase_i,
  input  logic          in_range_i,
  input  logic          is_lock_i,
  input  logic [DW-1:0] tgt_q_i,
  input  logic [DW-1:0] lock_q_i,
  input  logic [DW-1:0] wdata_i,
  output resp_e         resp_o,
  output logic          wr_en_o,
  output logic          lock_bad_o
);
  logic lock_open, lock_shut, set_bit;

  always_comb begin
    lock_open  = (lock_q_i == '1);
    lock_shut  = (lock_q_i == '0);
    set_bit    = |(wdata_i & ~tgt_q_i);
    resp_o     = RESP_OK;
    wr_en_o    = 1'b0;
    lock_bad_o = 1'b0;
    if (req_i) begin
      if (!in_range_i)                    resp_o = RESP_ADDR;
      else if (erase_i)                   resp_o = RESP_ERASE;
      else if (we_i) begin
        if (!is_lock_i && !lock_open) begin
          resp_o     = RESP_LOCKED;
          lock_bad_o = !lock_shut;
        end else if (set_bit)             resp_o = RESP_SETBIT;
        else                              wr_en_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/otp_lock_mem.sv
module otp_lock_mem
  import otp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          erase_i,
  input  logic [9:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          ack_o,
  output logic          err_o,
  output logic [2:0]    resp_o,
  output logic          lock_bad_o
);
  logic             in_range, is_lock, wr_en, lock_bad;
  logic [IDX_W-1:0] tgt_idx, lock_idx;
  logic [DW-1:0]    tgt_q, lock_q;
  resp_e            resp;

  otp_addr_dec u_dec (
    .addr_i     (addr_i),
    .in_range_o (in_range),
    .is_lock_o  (is_lock),
    .tgt_idx_o  (tgt_idx),
    .lock_idx_o (lock_idx)
  );

  otp_cell_array u_cells (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tgt_idx_i  (tgt_idx),
    .lock_idx_i (lock_idx),
    .tgt_q_o    (tgt_q),
    .lock_q_o   (lock_q),
    .wr_en_i    (wr_en),
    .wr_data_i  (wdata_i)
  );

  otp_prog_ctrl u_ctrl (
    .req_i      (req_i),
    .we_i       (we_i),
    .erase_i    (erase_i),
    .in_range_i (in_range),
    .is_lock_i  (is_lock),
    .tgt_q_i    (tgt_q),
    .lock_q_i   (lock_q),
    .wdata_i    (wdata_i),
    .resp_o     (resp),
    .wr_en_o    (wr_en),
    .lock_bad_o (lock_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      err_o      <= 1'b0;
      resp_o     <= '0;
      lock_bad_o <= 1'b0;
      rdata_o    <= '0;
    end else begin
      ack_o      <= req_i;
      err_o      <= req_i && (resp != RESP_OK);
      resp_o     <= req_i ? resp : RESP_OK;
      lock_bad_o <= lock_bad;
      rdata_o    <= (req_i && !we_i && !erase_i && in_range) ? tgt_q : '0;
    end
  end

  assert_ack_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  assert_no_ack_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  assert_err_with_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ack_o);
  assert_erase_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && erase_i) |-> !wr_en);
  assert_locked_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !is_lock) |-> (lock_q == 8'hFF));
  assert_bad_is_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_bad_o |-> (err_o && resp_o == 3'(RESP_LOCKED)));
  assert_range_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && 32'(addr_i) >= TOTAL_BYTES) |=> (resp_o == 3'(RESP_ADDR)));
endmodule

// File: tb/otp_lock_mem_test.sv
`timescale 1ns/1ps
module otp_lock_mem_test;
  localparam time CLK_P = 8ns;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0, erase_i = 1'b0;
  logic [9:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ack_o, err_o, lock_bad_o;
  logic [2:0] resp_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  otp_lock_mem uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .erase_i(erase_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o),
    .err_o(err_o), .resp_o(resp_o), .lock_bad_o(lock_bad_o)
  );

  // {erase, we, addr[9:0], wdata[7:0], resp[2:0], rdata[7:0], bad}
  localparam int NV = 24;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0,1'b0,10'h000,8'h00,3'd0,8'hFF,1'b0}, // R3 erased read
    {1'b0,1'b1,10'h000,8'hA5,3'd0,8'h00,1'b0}, // R4 clear bits
    {1'b0,1'b0,10'h000,8'h00,3'd0,8'hA5,1'b0}, // R3
    {1'b0,1'b1,10'h000,8'h25,3'd0,8'h00,1'b0}, // R4 subset
    {1'b0,1'b0,10'h000,8'h00,3'd0,8'h25,1'b0},
    {1'b0,1'b1,10'h000,8'hA5,3'd4,8'h00,1'b0}, // R5 restore bit 7
    {1'b0,1'b0,10'h000,8'h00,3'd0,8'h25,1'b0}, // R5 unchanged
    {1'b0,1'b1,10'h000,8'h25,3'd0,8'h00,1'b0}, // R4 same value
    {1'b1,1'b0,10'h000,8'h00,3'd2,8'h00,1'b0}, // R8
    {1'b0,1'b0,10'h000,8'h00,3'd0,8'h25,1'b0}, // R8 unchanged
    {1'b0,1'b0,10'h210,8'h00,3'd1,8'h00,1'b0}, // R9 first bad addr
    {1'b0,1'b1,10'h3FF,8'h00,3'd1,8'h00,1'b0}, // R9
    {1'b0,1'b1,10'h201,8'h00,3'd0,8'h00,1'b0}, // R10 lock block 1
    {1'b0,1'b0,10'h201,8'h00,3'd0,8'h00,1'b0},
    {1'b0,1'b1,10'h020,8'h00,3'd3,8'h00,1'b0}, // R6
    {1'b0,1'b0,10'h020,8'h00,3'd0,8'hFF,1'b0}, // R6 unchanged
    {1'b0,1'b1,10'h201,8'hFF,3'd4,8'h00,1'b0}, // R5 on lock byte
    {1'b0,1'b1,10'h202,8'h5A,3'd0,8'h00,1'b0}, // invalid lock value
    {1'b0,1'b1,10'h040,8'h00,3'd3,8'h00,1'b1}, // R7
    {1'b0,1'b0,10'h040,8'h00,3'd0,8'hFF,1'b0}, // R7 unchanged
    {1'b0,1'b1,10'h1FF,8'h00,3'd0,8'h00,1'b0}, // R4 last data byte
    {1'b0,1'b0,10'h1FF,8'h00,3'd0,8'h00,1'b0},
    {1'b1,1'b0,10'h201,8'h00,3'd2,8'h00,1'b0}, // R8 lock byte
    {1'b1,1'b0,10'h300,8'h00,3'd1,8'h00,1'b0}  // R9 priority over erase
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input bit er, input bit w, input logic [9:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; erase_i = er; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; erase_i = 1'b0; we_i = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] c, input bit w, input bit bad);
    if (bad)      return "R7";
    case (c)
      3'd1: return "R9";
      3'd2: return "R8";
      3'd3: return "R6";
      3'd4: return "R5";
      default: return w ? "R4" : "R3";
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ack_o == 0 && err_o == 0 && resp_o == 0 && lock_bad_o == 0 && rdata_o == 0,
        "R1 outputs in reset", {ack_o, err_o, resp_o, lock_bad_o, rdata_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ack_o == 0, "R2 idle no ack", ack_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string t;
      v = VEC[i];
      op(v[31], v[30], v[29:20], v[19:12]);
      t = tag_of(v[11:9], v[30], v[0]);
      chk(ack_o == 1'b1, "R2 ack", ack_o, 1);
      chk(resp_o == v[11:9], t, resp_o, v[11:9]);
      chk(err_o == (v[11:9] != 0), "R11 err", err_o, v[11:9] != 0);
      chk(lock_bad_o == v[0], "R7 flag", lock_bad_o, v[0]);
      if (!v[31] && !v[30] && v[11:9] == 0)
        chk(rdata_o == v[8:1], t, rdata_o, v[8:1]);
    end

    @(negedge clk_i);
    chk(ack_o == 0 && err_o == 0, "R2 ack lasts one cycle", ack_o, 0);

    // R10: rewrite 0x00 onto an already locked lock byte
    op(0, 1, 10'h201, 8'h00);
    chk(resp_o == 0 && err_o == 0, "R10 relock accepted", resp_o, 0);

    // back-to-back requests: two acks in a row
    @(negedge clk_i);
    req_i = 1; addr_i = 10'h000;
    @(negedge clk_i);
    chk(ack_o == 1 && rdata_o == 8'h25, "R2 back-to-back 1", rdata_o, 8'h25);
    addr_i = 10'h201;
    @(negedge clk_i);
    req_i = 0;
    chk(ack_o == 1 && rdata_o == 8'h00, "R3 back-to-back 2", rdata_o, 8'h00);

    // R1: reset mid-run restores erased cells
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(ack_o == 0 && rdata_o == 0, "R1 reset outputs", ack_o, 0);
    rst_ni = 1'b1;
    op(0, 0, 10'h000, 8'h00);
    chk(rdata_o == 8'hFF, "R1 data cell erased", rdata_o, 8'hFF);
    op(0, 0, 10'h201, 8'h00);
    chk(rdata_o == 8'hFF, "R1 lock cell erased", rdata_o, 8'hFF);
    op(0, 1, 10'h020, 8'h3C);
    chk(resp_o == 0, "R4 block unlocked after reset", resp_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule